// File: doc/BRIEF.md
# PWM Timebase Counter with Byte-Wide CPU View

This block holds the free-running count that paces a pair of pulse-width D/A channels. A selectable pulse from a set of prescaled ticks advances a 14-bit count by one. Each channel picks its own precision. A wide channel watches all 14 count bits. A narrow channel watches only the low 12 bits, and it is told of a rollover each time those 12 bits wrap.

Software sees the count through an 8-bit bus as a 16-bit word. The upper byte holds count bits 0..7. The lower byte holds count bits 8..13 in reversed placement, a constant one, and a bank-select flag that neighbouring logic decodes. A byte-wide holding latch keeps 16-bit transfers coherent while the count keeps moving. Reset, a halt request or a dropped run enable put the word back to 0x0003.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the CPU word reads 0x0003: the upper byte returns 0x00, the lower byte (after an upper-byte read) returns 0x03, and `reg_sel_o` is 1.
- R2: While running, the count rises by exactly one in each cycle in which `tick_in[tick_sel]` is high; pulses on the other tick inputs leave it unchanged.
- R3: An upper-byte read returns count bits 7..0. The lower byte has count bit 8 at bit 7 down to count bit 13 at bit 2, a constant 1 at bit 1 and the select flag at bit 0.
- R4: An upper-byte read copies the lower byte into the holding latch in the same cycle. A later lower-byte read returns that copy, even if the count has moved in between.
- R5: An upper-byte write only fills the holding latch and leaves the count alone. A lower-byte write loads the whole word in one cycle, with the latch as the upper byte, and it wins over a tick in the same cycle.
- R6: The select flag takes bit 0 of a lower-byte write and is driven on `reg_sel_o`.
- R7: While `halt` is 1 or `run_en` is 0, the count is held at 0 and the select flag at 1. Ticks and lower-byte writes have no effect during that time.
- R8: A wide channel raises its `wrap_o` bit for exactly one cycle, in the cycle after the count steps from 0x3FFF to 0.
- R9: A narrow channel (`ch_wide` bit 0) sees a window of count bits 11..0 with the top two bits zero. Its `wrap_o` bit pulses for one cycle after every rollover of those 12 bits.
- R10: A wide channel (`ch_wide` bit 1) sees the full 14-bit count on its `win_o` slice, which is bits [14*ch+13 : 14*ch].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Run enable; 0 holds the word at 0x0003 |
| halt | input | 1 | Low-power or stop request; 1 holds the word at 0x0003 |
| tick_in | input | NUM_TICK | Prescaled count pulses |
| tick_sel | input | SEL_W | Index of the pulse that advances the count |
| bus_rd | input | 1 | Byte read strobe for this word |
| bus_wr | input | 1 | Byte write strobe for this word |
| bus_hi | input | 1 | 1 selects the upper byte, 0 the lower byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| reg_sel_o | output | 1 | Bank-select flag |
| ch_wide | input | NUM_CH | Per-channel precision, 1 = 14 bits |
| win_o | output | NUM_CH*14 | Per-channel compare window |
| wrap_o | output | NUM_CH | Per-channel one-cycle rollover pulse |

## Verification
In the same cycle, a lower-byte write and a selected tick can both try to set the count, and a halt can override both of them. The bench provokes the first case by raising the write strobe and the selected tick on the same edge. It passes only if the window then shows the written value and not that value plus one. The bench provokes the second case by holding `halt` while it issues ticks and a write, and then checks that the window stays at zero. It also checks that a stale latch copy survives ticks that land between an upper-byte read and the matching lower-byte read.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
    localparam int CNT_W  = 14;
    localparam int BYTE_W = 8;
    localparam int VIEW_W = 2 * BYTE_W;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              sel;
        logic [BYTE_W-1:0] hold;
    } ptb_state_t;
endpackage

// File: rtl/ptb_tick_select.sv
module ptb_tick_select #(
    parameter int NUM_TICK = 4,
    localparam int SEL_W   = (NUM_TICK > 1) ? $clog2(NUM_TICK) : 1
) (
    input  logic [NUM_TICK-1:0] tick_in,
    input  logic [SEL_W-1:0]    tick_sel,
    output logic                tick_o
);
    logic [NUM_TICK-1:0] match;

    for (genvar i = 0; i < NUM_TICK; i++) begin : g_src
        assign match[i] = tick_in[i] && (tick_sel == SEL_W'(i));
    end

    assign tick_o = |match;
endmodule

// File: rtl/ptb_view_map.sv
module ptb_view_map
    import ptb_pkg::*;
(
    input  logic [CNT_W-1:0]  cnt,
    input  logic              sel,
    output logic [VIEW_W-1:0] view,
    input  logic [VIEW_W-1:0] load_view,
    output logic [CNT_W-1:0]  load_cnt,
    output logic              load_sel
);
    // low count byte sits straight in the upper CPU byte
    for (genvar i = 0; i < BYTE_W; i++) begin : g_lo
        assign view[BYTE_W+i] = cnt[i];
        assign load_cnt[i]    = load_view[BYTE_W+i];
    end

    // upper count bits run backwards from CPU bit 7
    for (genvar i = BYTE_W; i < CNT_W; i++) begin : g_hi
        assign view[VIEW_W-1-i] = cnt[i];
        assign load_cnt[i]      = load_view[VIEW_W-1-i];
    end

    assign view[1]  = 1'b1;
    assign view[0]  = sel;
    assign load_sel = load_view[0];

    logic unused_fixed;
    assign unused_fixed = load_view[1];
endmodule

// File: rtl/ptb_window.sv
module ptb_window #(
    parameter int CNT_W = 14,
    parameter int LOW_W = 12
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             wide,
    input  logic             step,
    output logic [CNT_W-1:0] win,
    output logic             roll
);
    always_comb begin
        if (wide) begin
            win  = cnt;
            roll = step && (&cnt);
        end else begin
            win  = {{(CNT_W-LOW_W){1'b0}}, cnt[LOW_W-1:0]};
            roll = step && (&cnt[LOW_W-1:0]);
        end
    end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import ptb_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int NUM_TICK = 4,
    parameter int LOW_W    = 12,
    localparam int SEL_W   = (NUM_TICK > 1) ? $clog2(NUM_TICK) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run_en,
    input  logic                    halt,
    input  logic [NUM_TICK-1:0]     tick_in,
    input  logic [SEL_W-1:0]        tick_sel,
    input  logic                    bus_rd,
    input  logic                    bus_wr,
    input  logic                    bus_hi,
    input  logic [7:0]              bus_wdata,
    output logic [7:0]              bus_rdata,
    output logic                    reg_sel_o,
    input  logic [NUM_CH-1:0]       ch_wide,
    output logic [NUM_CH*CNT_W-1:0] win_o,
    output logic [NUM_CH-1:0]       wrap_o
);
    localparam ptb_state_t RST_ST = '{cnt: '0, sel: 1'b1, hold: '0};

    ptb_state_t        st_d, st_q;
    logic [NUM_CH-1:0] wrap_d, wrap_q;

    logic              tick_hit;
    logic [VIEW_W-1:0] view;
    logic [CNT_W-1:0]  load_cnt;
    logic              load_sel;
    logic [NUM_CH-1:0] roll;
    logic              forced, step, wr_lo, wr_hi, rd_hi;

    ptb_tick_select #(.NUM_TICK(NUM_TICK)) u_tick (
        .tick_in (tick_in),
        .tick_sel(tick_sel),
        .tick_o  (tick_hit)
    );

    ptb_view_map u_map (
        .cnt      (st_q.cnt),
        .sel      (st_q.sel),
        .view     (view),
        .load_view({st_q.hold, bus_wdata}),
        .load_cnt (load_cnt),
        .load_sel (load_sel)
    );

    assign forced = halt || !run_en;
    assign wr_lo  = bus_wr && !bus_hi;
    assign wr_hi  = bus_wr && bus_hi;
    assign rd_hi  = bus_rd && bus_hi;
    assign step   = tick_hit && !forced && !wr_lo;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ptb_window #(.CNT_W(CNT_W), .LOW_W(LOW_W)) u_win (
            .cnt (st_q.cnt),
            .wide(ch_wide[c]),
            .step(step),
            .win (win_o[c*CNT_W +: CNT_W]),
            .roll(roll[c])
        );
    end

    always_comb begin
        st_d   = st_q;
        wrap_d = '0;
        if (rd_hi) begin
            st_d.hold = view[BYTE_W-1:0];
        end
        if (wr_hi) begin
            st_d.hold = bus_wdata;
        end
        if (forced) begin
            st_d.cnt = '0;
            st_d.sel = 1'b1;
        end else if (wr_lo) begin
            st_d.cnt = load_cnt;
            st_d.sel = load_sel;
        end else if (step) begin
            st_d.cnt = st_q.cnt + 1'b1;
            wrap_d   = roll;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= RST_ST;
            wrap_q <= '0;
        end else begin
            st_q   <= st_d;
            wrap_q <= wrap_d;
        end
    end

    always_comb begin
        if (!bus_rd) begin
            bus_rdata = '0;
        end else if (bus_hi) begin
            bus_rdata = view[VIEW_W-1:BYTE_W];
        end else begin
            bus_rdata = st_q.hold;
        end
    end

    assign reg_sel_o = st_q.sel;
    assign wrap_o    = wrap_q;
endmodule

// File: rtl/ptb_timebase_chk.sv
module ptb_timebase_chk #(
    parameter int NUM_CH   = 2,
    parameter int NUM_TICK = 4,
    parameter int LOW_W    = 12,
    parameter int CNT_W    = 14,
    parameter int SEL_W    = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                run_en,
    input logic                halt,
    input logic [NUM_TICK-1:0] tick_in,
    input logic [SEL_W-1:0]    tick_sel,
    input logic                bus_rd,
    input logic                bus_wr,
    input logic                bus_hi,
    input logic                reg_sel_o,
    input logic [NUM_CH-1:0]   wrap_o,
    input logic [CNT_W-1:0]    cnt_q,
    input logic [7:0]          hold_q
);
    logic chosen;
    assign chosen = (int'(tick_sel) < NUM_TICK) ? tick_in[tick_sel] : 1'b0;

    // R2
    tick_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !halt && chosen && !(bus_wr && !bus_hi))
        |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R2
    tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !halt && !chosen && !(bus_wr && !bus_hi)) |=> $stable(cnt_q));

    // R7
    force_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt || !run_en) |=> (cnt_q == '0 && reg_sel_o));

    // R8
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|wrap_o) |-> (cnt_q[LOW_W-1:0] == '0));

    // R4
    hold_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_hi && !bus_wr) |=> hold_q[1]);

    // R5
    lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !halt && bus_wr && !bus_hi) |=> (cnt_q[7:0] == $past(hold_q)));
endmodule

bind pwm_timebase ptb_timebase_chk #(
    .NUM_CH(NUM_CH), .NUM_TICK(NUM_TICK), .LOW_W(LOW_W),
    .CNT_W(ptb_pkg::CNT_W), .SEL_W(SEL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .halt     (halt),
    .tick_in  (tick_in),
    .tick_sel (tick_sel),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_hi   (bus_hi),
    .reg_sel_o(reg_sel_o),
    .wrap_o   (wrap_o),
    .cnt_q    (st_q.cnt),
    .hold_q   (st_q.hold)
);

// File: tb/pwm_timebase_bench.sv
`timescale 1ns/1ps
module pwm_timebase_bench;
    localparam int NUM_CH = 2;
    localparam int NUM_TICK = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b1;
    logic        halt = 1'b0;
    logic [3:0]  tick_in = '0;
    logic [1:0]  tick_sel = 2'd2;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_hi = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        reg_sel_o;
    logic [1:0]  ch_wide = 2'b11;
    logic [27:0] win_o;
    logic [1:0]  wrap_o;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pwm_timebase #(.NUM_CH(NUM_CH), .NUM_TICK(NUM_TICK), .LOW_W(12)) u_pwm_timebase (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .halt(halt),
        .tick_in(tick_in), .tick_sel(tick_sel),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_hi(bus_hi),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .reg_sel_o(reg_sel_o),
        .ch_wide(ch_wide), .win_o(win_o), .wrap_o(wrap_o)
    );

    // fields: load hi, load lo, tick count, expected hi, expected lo
    localparam logic [39:0] VEC [0:5] = '{
        {8'h00, 8'h03, 8'd1,  8'h01, 8'h03},
        {8'hFE, 8'h02, 8'd3,  8'h01, 8'h82},
        {8'hFF, 8'hFF, 8'd1,  8'h00, 8'h03},
        {8'h10, 8'h04, 8'd0,  8'h10, 8'h06},
        {8'hF0, 8'h41, 8'd16, 8'h00, 8'hC3},
        {8'hFF, 8'h0C, 8'd1,  8'h00, 8'h8E}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic hi, input logic [7:0] d);
        bus_wr = 1'b1; bus_hi = hi; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_byte(input logic hi, output logic [7:0] d);
        bus_rd = 1'b1; bus_hi = hi;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            tick_in[tick_sel] = 1'b1;
            @(negedge clk);
            tick_in = '0;
        end
    endtask

    task automatic load(input logic [7:0] hi, input logic [7:0] lo);
        wr_byte(1'b1, hi);
        wr_byte(1'b0, lo);
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] h, l;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset word
        check("R1 sel", 32'(reg_sel_o), 32'h1);
        rd_byte(1'b1, h); rd_byte(1'b0, l);
        check("R1 hi", 32'(h), 32'h00);
        check("R1 lo", 32'(l), 32'h03);

        // R3 R6 R2 vector walk
        for (int v = 0; v < 6; v++) begin
            load(VEC[v][39:32], VEC[v][31:24]);
            pulse(int'(VEC[v][23:16]));
            rd_byte(1'b1, h); rd_byte(1'b0, l);
            check("R3 hi", 32'(h), 32'(VEC[v][15:8]));
            check("R3 lo", 32'(l), 32'(VEC[v][7:0]));
            check("R6 sel", 32'(reg_sel_o), 32'(VEC[v][0]));
        end

        // R2 unselected ticks ignored
        load(8'h40, 8'h01);
        tick_in = 4'b1011;
        @(negedge clk);
        tick_in = '0;
        check("R2 other ticks", 32'(win_o[13:0]), 32'h0040);
        pulse(2);
        check("R2 selected", 32'(win_o[13:0]), 32'h0042);

        // R4 stale hold copy
        load(8'hFF, 8'h03);
        rd_byte(1'b1, h);
        pulse(1);
        rd_byte(1'b0, l);
        check("R4 stale lo", 32'(l), 32'h03);
        rd_byte(1'b1, h); rd_byte(1'b0, l);
        check("R4 fresh hi", 32'(h), 32'h00);
        check("R4 fresh lo", 32'(l), 32'h83);

        // R5 hi write alone, then lo write beats a tick
        load(8'h20, 8'h01);
        wr_byte(1'b1, 8'h12);
        check("R5 hi only", 32'(win_o[13:0]), 32'h0020);
        tick_in[tick_sel] = 1'b1;
        wr_byte(1'b0, 8'h00);
        tick_in = '0;
        check("R5 collision", 32'(win_o[13:0]), 32'h0012);
        check("R6 sel clr", 32'(reg_sel_o), 32'h0);

        // R7 halt and dropped enable
        load(8'h55, 8'h80);
        halt = 1'b1;
        pulse(3);
        wr_byte(1'b0, 8'hFC);
        check("R7 halt win", 32'(win_o[13:0]), 32'h0);
        check("R7 halt sel", 32'(reg_sel_o), 32'h1);
        halt = 1'b0;
        load(8'h33, 8'h40);
        run_en = 1'b0;
        pulse(2);
        check("R7 run_en win", 32'(win_o[13:0]), 32'h0);
        run_en = 1'b1;
        rd_byte(1'b1, h); rd_byte(1'b0, l);
        check("R7 word hi", 32'(h), 32'h00);
        check("R7 word lo", 32'(l), 32'h03);

        // R8 full wrap
        load(8'hFF, 8'hFF);
        check("R8 no early wrap", 32'(wrap_o), 32'h0);
        pulse(1);
        check("R8 wrap pulse", 32'(wrap_o), 32'h3);
        check("R8 wrapped", 32'(win_o[13:0]), 32'h0);
        @(negedge clk);
        check("R8 one cycle", 32'(wrap_o), 32'h0);

        // R9 R10 mixed precision
        ch_wide = 2'b01;
        load(8'hFF, 8'hFB);
        check("R10 wide win", 32'(win_o[13:0]), 32'h1FFF);
        check("R9 narrow win", 32'(win_o[27:14]), 32'h0FFF);
        pulse(1);
        check("R9 narrow wrap", 32'(wrap_o), 32'h2);
        check("R10 wide next", 32'(win_o[13:0]), 32'h2000);
        check("R9 narrow zero", 32'(win_o[27:14]), 32'h0000);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule